// File: doc/BRIEF.md
# Bit-Alias Bus Translator

This block sits between one bus master and a word-addressed memory port. Each of two bit-addressable regions (one starting at 0x20000000, one at 0x40000000, each 1 MB) has a 32 MB alias window. In that window every 32-bit word of the region is spread out so that each of its bits gets its own word address. An access that falls outside both alias windows goes straight to the memory in the same cycle. A write into an alias window becomes an atomic read-modify-write of one bit in the backing word. A read from an alias window returns that one bit in bit 0 of the read data, with every other bit zero.

The master keeps its request stable while `m_stall` is high. The access completes in the first cycle in which `m_stall` is low. The state machine has four states. ST_IDLE takes a new request. ST_RD reads the backing word. ST_WR writes the merged word back. ST_DONE returns the result and releases the master. The transitions are: IDLE→RD when an alias access is accepted; RD→WR for an alias write; RD→DONE for an alias read; WR→DONE after the write-back; DONE→IDLE always; IDLE→IDLE for an idle bus or a plain access.

Top module: `bbx_alias_xlate`

## Requirements
- R1: When a request is presented in ST_IDLE and its address is outside both alias windows, it passes through in the same cycle. `m_stall` stays 0. The memory sees the same address, write flag and write data. `m_rdata` equals `s_rdata`. Exactly one memory access takes place.
- R2: An address lies in an alias window when it falls in [base+0x02000000, base+0x04000000) for base 0x20000000 or 0x40000000. For such an address, the backing word address is base + addr[24:7]×4 and the bit number is addr[6:2]. Addresses outside these windows (for example 0x24000000) are plain accesses.
- R3: An alias write sets or clears the addressed bit of the backing word and leaves the other 31 bits of that word unchanged.
- R4: An alias read returns the addressed bit in `m_rdata[0]` with `m_rdata[31:1]` zero, and does not write the memory.
- R5: Only bit 0 of `m_wdata` is used by an alias write. Bits 31:1 have no effect on the stored word.
- R6: Starting from a cleared word at 0x20000000, alias writes of 1 to bits 0, 1, 31 and 30 (alias addresses 0x22000000, 0x22000004, 0x2200007C and 0x22000078) leave 0xC0000003. A further alias write of 0 to bit 0 leaves 0xC0000002.
- R7: An alias write follows IDLE→RD→WR→DONE. `m_stall` is high for 3 cycles and the access completes in the 4th cycle. An alias read follows IDLE→RD→DONE. `m_stall` is high for 2 cycles and the read completes in the 3rd cycle.
- R8: The read and the write-back of an alias write are issued on back-to-back cycles at the same backing address. No other memory access is issued between them or in ST_DONE.
- R9: After reset the block is in ST_IDLE. With no request presented, `m_stall` and `s_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master access request, held while stalled |
| m_we | input | 1 | Master write flag |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data to the master |
| m_stall | output | 1 | Hold-off to the master |
| s_req | output | 1 | Memory access request |
| s_we | output | 1 | Memory write flag |
| s_addr | output | 32 | Memory word address (byte units) |
| s_wdata | output | 32 | Memory write data |
| s_rdata | input | 32 | Memory read data, valid in the cycle of the request |

## Verification
The cycle at risk is ST_DONE. In that cycle the completing alias request is still on the master port, and the block must neither start it a second time nor touch the memory. The bench runs alias accesses back to back with plain accesses and with each other, so that a new request is presented right after each release. It counts every memory access in each transaction: exactly two (a read, then a write at the same address) for an alias write, one read for an alias read, and one for a plain access. A stray access in the DONE cycle, or a re-accepted request, shows up as a wrong access count or a wrong stall length.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_DONE
    } bbx_state_e;
endpackage

// File: rtl/bbx_decode.sv
module bbx_decode #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_LOG2 = 20,
    parameter int NUM_REG     = 2,
    parameter logic [NUM_REG*ADDR_W-1:0] BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [ADDR_W-1:0]         word_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int BIT_LOG2   = $clog2(DATA_W);
    localparam int BYTE_LOG2  = $clog2(DATA_W / 8);
    localparam int ALIAS_LOG2 = REGION_LOG2 + BIT_LOG2;
    localparam int WIDX_W     = REGION_LOG2 - BYTE_LOG2;
    localparam logic [ADDR_W-1:0] ALIAS_OFS = ADDR_W'(1) << ALIAS_LOG2;

    logic [NUM_REG-1:0] match;
    logic [ADDR_W-1:0]  masked [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_region
        localparam logic [ADDR_W-1:0] BASE_R = BASES[r*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] WIN_R  = BASE_R + ALIAS_OFS;
        assign match[r]  = (addr[ADDR_W-1:ALIAS_LOG2] == WIN_R[ADDR_W-1:ALIAS_LOG2]);
        assign masked[r] = match[r] ? BASE_R : '0;
    end

    logic [ADDR_W-1:0] base_sel;
    always_comb begin
        base_sel = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            base_sel = base_sel | masked[r];
        end
    end

    assign hit       = |match;
    assign bit_idx   = addr[BYTE_LOG2 +: BIT_LOG2];
    assign word_addr = base_sel
                     | (ADDR_W'(addr[BYTE_LOG2 + BIT_LOG2 +: WIDX_W]) << BYTE_LOG2);
endmodule

// File: rtl/bbx_merge.sv
module bbx_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         word,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      bit_val,
    output logic [DATA_W-1:0]         merged,
    output logic                      picked
);
    localparam int BIT_LOG2 = $clog2(DATA_W);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged[i] = (bit_idx == BIT_LOG2'(i)) ? bit_val : word[i];
    end

    assign picked = word[bit_idx];
endmodule

// File: rtl/bbx_alias_xlate.sv
module bbx_alias_xlate
    import bbx_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_LOG2 = 20,
    parameter int NUM_REG     = 2,
    parameter logic [NUM_REG*ADDR_W-1:0] BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_stall,
    output logic              s_req,
    output logic              s_we,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W-1:0] s_rdata
);
    localparam int BIT_LOG2 = $clog2(DATA_W);

    bbx_state_e          state_q, state_d;
    logic                hit;
    logic [ADDR_W-1:0]   dec_word;
    logic [BIT_LOG2-1:0] dec_bit;
    logic [ADDR_W-1:0]   addr_q;
    logic [BIT_LOG2-1:0] bit_q;
    logic                we_q;
    logic                wbit_q;
    logic [DATA_W-1:0]   word_q;
    logic [DATA_W-1:0]   merged;
    logic                picked;
    logic                accept;

    bbx_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_LOG2(REGION_LOG2),
        .NUM_REG(NUM_REG), .BASES(BASES)
    ) u_decode (
        .addr(m_addr), .hit(hit), .word_addr(dec_word), .bit_idx(dec_bit)
    );

    bbx_merge #(.DATA_W(DATA_W)) u_merge (
        .word(word_q), .bit_idx(bit_q), .bit_val(wbit_q),
        .merged(merged), .picked(picked)
    );

    assign accept = (state_q == ST_IDLE) && m_req && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RD;
            ST_RD:   state_d = we_q ? ST_WR : ST_DONE;
            ST_WR:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            bit_q   <= '0;
            we_q    <= 1'b0;
            wbit_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= dec_word;
                bit_q  <= dec_bit;
                we_q   <= m_we;
                wbit_q <= m_wdata[0];
            end
            if (state_q == ST_RD) begin
                word_q <= s_rdata;
            end
        end
    end

    always_comb begin
        m_stall = 1'b0;
        m_rdata = '0;
        s_req   = 1'b0;
        s_we    = 1'b0;
        s_addr  = '0;
        s_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (m_req && !hit) begin
                    s_req   = 1'b1;
                    s_we    = m_we;
                    s_addr  = m_addr;
                    s_wdata = m_wdata;
                    m_rdata = s_rdata;
                end else if (m_req) begin
                    m_stall = 1'b1;
                end
            end
            ST_RD: begin
                m_stall = 1'b1;
                s_req   = 1'b1;
                s_addr  = addr_q;
            end
            ST_WR: begin
                m_stall = 1'b1;
                s_req   = 1'b1;
                s_we    = 1'b1;
                s_addr  = addr_q;
                s_wdata = merged;
            end
            ST_DONE: begin
                m_rdata = {{(DATA_W-1){1'b0}}, picked};
            end
        endcase
    end

    // R1: a plain access is forwarded unstalled
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && m_req && !hit) |-> (!m_stall && s_req && s_addr == m_addr));

    // R3: the write-back keeps every bit but the target, and loads the target from write data bit 0
    a_r3_keep_others: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |->
            (((s_wdata ^ $past(s_rdata)) & ~(DATA_W'(1) << bit_q)) == '0));
    a_r3_target_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |-> (s_wdata[bit_q] == m_wdata[0]));

    // R4: alias read data carries one bit
    a_r4_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (m_rdata[DATA_W-1:1] == '0));

    // R8: write-back follows the read at the same address, and DONE is silent
    a_r8_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_we && state_q == ST_WR) |->
            ($past(s_req) && !$past(s_we) && s_addr == $past(s_addr)));
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (!s_req && !m_stall));

    // R7: an accepted alias access keeps the master stalled on the next cycle
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> m_stall);
endmodule

// File: tb/bbx_alias_xlate_tb.sv
module bbx_alias_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0;
    logic        m_we = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_stall;
    logic        s_req;
    logic        s_we;
    logic [31:0] s_addr;
    logic [31:0] s_wdata;
    logic [31:0] s_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    bbx_alias_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_stall(m_stall), .s_req(s_req),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    // memory model: 64 words per region, region chosen by address bit 30
    logic [31:0] mem [128];
    logic [31:0] expm [128];
    function automatic int midx(input logic [31:0] a);
        return {25'd0, a[30], a[7:2]};
    endfunction
    assign s_rdata = mem[midx(s_addr)];
    always @(posedge clk) if (s_req && s_we) mem[midx(s_addr)] <= s_wdata;

    // access monitor
    int          n_acc;
    logic [31:0] acc_addr [4];
    logic        acc_we [4];
    always @(posedge clk) begin
        if (s_req) begin
            if (n_acc < 4) begin
                acc_addr[n_acc] <= s_addr;
                acc_we[n_acc]   <= s_we;
            end
            n_acc <= n_acc + 1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt == 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc_cnt);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int cycles);
        @(negedge clk);
        n_acc   = 0;
        m_req   = 1'b1;
        m_we    = we;
        m_addr  = addr;
        m_wdata = wd;
        cycles  = 1;
        #1;
        while (m_stall) begin
            @(negedge clk);
            #1;
            cycles++;
        end
        rd = m_rdata;
        @(posedge clk);
        #1;
        m_req = 1'b0;
    endtask

    function automatic logic [31:0] alias_of(input logic [31:0] base, input int w, input int b);
        return base + 32'h0200_0000 + 32'(w * 128) + 32'(b * 4);
    endfunction

    logic [31:0] rd;
    int          cyc;

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]  = '0;
            expm[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(m_stall == 1'b0, "R9 stall after reset", 32'(m_stall), 0);
        check(s_req == 1'b0, "R9 no memory request after reset", 32'(s_req), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(m_stall == 1'b0 && s_req == 1'b0, "R9 idle bus quiet", {30'd0, m_stall, s_req}, 0);

        // R1: plain accesses in both regions
        access(1'b1, 32'h2000_0010, 32'hA5A5_0F0F, rd, cyc);
        expm[midx(32'h2000_0010)] = 32'hA5A5_0F0F;
        check(cyc == 1, "R1 plain write single cycle", 32'(cyc), 1);
        check(n_acc == 1 && acc_we[0] && acc_addr[0] == 32'h2000_0010,
              "R1 plain write forwarded", acc_addr[0], 32'h2000_0010);
        access(1'b0, 32'h2000_0010, 32'h0, rd, cyc);
        check(rd == 32'hA5A5_0F0F && cyc == 1, "R1 plain read data", rd, 32'hA5A5_0F0F);
        access(1'b1, 32'h4000_0020, 32'h1234_5678, rd, cyc);
        expm[midx(32'h4000_0020)] = 32'h1234_5678;
        access(1'b0, 32'h4000_0020, 32'h0, rd, cyc);
        check(rd == 32'h1234_5678 && n_acc == 1, "R1 plain read peripheral", rd, 32'h1234_5678);

        // R2: address beyond the alias window is plain
        access(1'b0, 32'h2400_0000, 32'h0, rd, cyc);
        check(cyc == 1 && n_acc == 1 && acc_addr[0] == 32'h2400_0000,
              "R2 outside window passes through", acc_addr[0], 32'h2400_0000);

        // clear words 0..3 of both regions
        for (int rg = 0; rg < 2; rg++) begin
            for (int w = 0; w < 4; w++) begin
                logic [31:0] ba;
                ba = (rg == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'(w * 4);
                access(1'b1, ba, 32'h0, rd, cyc);
                expm[midx(ba)] = '0;
            end
        end

        // R2 R3 R5 R7 R8: alias write sweep
        for (int rg = 0; rg < 2; rg++) begin
            for (int w = 0; w < 4; w++) begin
                logic [31:0] base;
                logic [31:0] ba;
                base = (rg == 0) ? 32'h2000_0000 : 32'h4000_0000;
                ba   = base + 32'(w * 4);
                for (int b = 0; b < 32; b++) begin
                    logic v;
                    logic [31:0] wd;
                    v  = ((b * 7 + w + rg) % 3) != 0;
                    wd = {31'(b * 40503 + w * 977 + rg), v};
                    access(1'b1, alias_of(base, w, b), wd, rd, cyc);
                    expm[midx(ba)][b] = v;
                    check(cyc == 4, "R7 alias write stall length", 32'(cyc), 4);
                    check(n_acc == 2 && !acc_we[0] && acc_we[1] &&
                          acc_addr[0] == ba && acc_addr[1] == ba,
                          "R8 read then write-back at backing word", acc_addr[1], ba);
                end
                access(1'b0, ba, 32'h0, rd, cyc);
                check(rd == expm[midx(ba)], "R3 R5 word after bit writes", rd, expm[midx(ba)]);
            end
        end

        // R4 R7: alias read sweep
        for (int rg = 0; rg < 2; rg++) begin
            for (int w = 0; w < 4; w++) begin
                logic [31:0] base;
                logic [31:0] ba;
                base = (rg == 0) ? 32'h2000_0000 : 32'h4000_0000;
                ba   = base + 32'(w * 4);
                for (int b = 0; b < 32; b++) begin
                    access(1'b0, alias_of(base, w, b), 32'hFFFF_FFFF, rd, cyc);
                    check(rd == {31'd0, expm[midx(ba)][b]}, "R4 alias read bit",
                          rd, {31'd0, expm[midx(ba)][b]});
                    check(cyc == 3 && n_acc == 1 && !acc_we[0], "R7 alias read length",
                          32'(cyc), 3);
                end
                access(1'b0, ba, 32'h0, rd, cyc);
                check(rd == expm[midx(ba)], "R4 alias reads leave word", rd, expm[midx(ba)]);
            end
        end

        // R6: fixed example
        access(1'b1, 32'h2000_0000, 32'h0, rd, cyc);
        access(1'b1, 32'h2200_0000, 32'h1, rd, cyc);
        access(1'b1, 32'h2200_0004, 32'h1, rd, cyc);
        access(1'b1, 32'h2200_007C, 32'h1, rd, cyc);
        access(1'b1, 32'h2200_0078, 32'h1, rd, cyc);
        access(1'b0, 32'h2000_0000, 32'h0, rd, cyc);
        check(rd == 32'hC000_0003, "R6 four bits set", rd, 32'hC000_0003);
        access(1'b1, 32'h2200_0000, 32'hFFFF_FFFE, rd, cyc);
        access(1'b0, 32'h2000_0000, 32'h0, rd, cyc);
        check(rd == 32'hC000_0002, "R5 R6 clear with upper bits set", rd, 32'hC000_0002);

        summary();
        $finish;
    end
endmodule